// File: doc/BRIEF.md
# Change-of-State Digital Input Port

This block watches 48 digital input lines and presents them to a host over a byte-wide register bus with an 8-byte address window. The inputs are only ever read; there is no output driver and no direction control. Six of the offsets return one input byte each. Offsets 0, 1 and 2 return bytes 0 to 2. Offsets 4, 5 and 6 return bytes 3 to 5. Offset 3 is a gap that returns zero. The data comes from a two-flop synchronizer, so host reads never see a raw asynchronous pin.

The inputs form six banks of eight lines. Any edge, rising or falling, on a line in a bank that has interrupts enabled latches that bank's status bit and pulls the active-low request line low. Offset 7 does two jobs. A write loads the per-bank enable mask. A read returns the latched bank flags and an active-low pending flag, and the same read acknowledges them. Reset leaves every bank disabled.

Top module: `cos_input_port`

## Requirements
- R1: After reset the enable mask is zero, no status bit is set, the request line `irq_n` is high, and offset 7 reads 0x40.
- R2: Reads at offsets 0, 1, 2, 4, 5 and 6 return synchronized input bytes 0 to 5 in that order. Byte n is `din[8n+7:8n]`. A change on `din` reaches the read data after two rising clock edges.
- R3: A read at offset 3 returns 0x00 whatever the inputs are.
- R4: In a bank whose enable bit is set, a rising or a falling edge on any of its eight inputs sets status bit n (bank n = inputs 8n to 8n+7). The bit is set at the third rising edge after the input change.
- R5: An edge in a bank whose enable bit is clear sets no status bit and leaves `irq_n` high.
- R6: A read at offset 7 (`rd_en` high with `addr` = 7) returns the status byte. Bits 5:0 are the latched bank flags, bit 6 is 0 when any flag is set and 1 otherwise, and bit 7 is 0. The clock edge that ends the read clears bits 5:0, so `irq_n` goes high again.
- R7: A bank edge that would latch in the same cycle as a clearing read at offset 7 is not lost. It is missing from that read's data and present at the next read.
- R8: A write at offset 7 loads `wdata[5:0]` as the enable mask, bit n for bank n. Any latched flag of a bank that the write disables is dropped. Writes to offsets 0 to 6 change neither the mask nor the status.
- R9: `irq_n` is low exactly when at least one bank flag is latched. Writing 0 to offset 7 therefore releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 48 | Asynchronous digital input lines |
| addr | input | 3 | Register offset within the window |
| rd_en | input | 1 | Read strobe; one cycle per read |
| wr_en | input | 1 | Write strobe; one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current `addr` |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach from the ports is an edge that lands in the very cycle of a clearing status read. It can be reached only by counting the three register stages between a pin and the status latch. The stimulus toggles a bank at a falling clock edge, waits exactly two cycles and then issues the read. That read must omit the new bank, and the next read must show it. The bench also sweeps every enable-mask value against a change on all banks, and it toggles every single input up and then down with every bank enabled. Together these exercise the bank grouping, the edge polarity and the masking.

// File: rtl/cos_pkg.sv
package cos_pkg;

    localparam int BANK_W    = 8;
    localparam int NUM_BANKS = 6;
    localparam int ADDR_W    = 3;
    localparam int IN_W      = BANK_W * NUM_BANKS;

    localparam logic [ADDR_W-1:0] OFS_GAP  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd7;
    localparam int                STAT_PEND_BIT = 6;

    typedef struct packed {
        logic       hit;
        logic [2:0] bank;
    } port_sel_t;

    // Offsets below the gap map straight to banks; offsets above it are shifted down by one.
    function automatic port_sel_t decode_port(logic [ADDR_W-1:0] ofs);
        port_sel_t sel;
        sel.hit  = 1'b0;
        sel.bank = 3'd0;
        if (ofs < OFS_GAP) begin
            sel.hit  = 1'b1;
            sel.bank = ofs;
        end else if (ofs > OFS_GAP && ofs < OFS_CTRL) begin
            sel.hit  = 1'b1;
            sel.bank = ofs - 3'd1;
        end
        return sel;
    endfunction

endpackage

// File: rtl/cos_sync_stage.sv
module cos_sync_stage #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] sync,
    output logic [W-1:0] edge_vec
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = din;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync     = sync_q.s2;
    assign edge_vec = sync_q.s2 ^ sync_q.prev;

endmodule

// File: rtl/cos_bank_reduce.sv
module cos_bank_reduce #(
    parameter int NB = 6,
    parameter int BW = 8
) (
    input  logic [NB*BW-1:0] edge_vec,
    output logic [NB-1:0]    bank_chg
);

    for (genvar g = 0; g < NB; g++) begin : g_bank
        assign bank_chg[g] = |edge_vec[g*BW +: BW];
    end

endmodule

// File: rtl/cos_status.sv
module cos_status #(
    parameter int NB = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] bank_chg,
    input  logic          wr_mask,
    input  logic [NB-1:0] mask_in,
    input  logic          rd_ack,
    output logic [NB-1:0] enable_q,
    output logic [NB-1:0] status_q,
    output logic          pending
);

    typedef struct packed {
        logic [NB-1:0] en;
        logic [NB-1:0] st;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [NB-1:0] kept;
    logic [NB-1:0] fresh;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_mask) begin
            ctl_d.en = mask_in;
        end
        // the acknowledge drops only what was already latched; new edges survive it
        kept     = rd_ack ? '0 : ctl_q.st;
        fresh    = bank_chg & ctl_q.en;
        ctl_d.st = (kept | fresh) & ctl_d.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign enable_q = ctl_q.en;
    assign status_q = ctl_q.st;
    assign pending  = |ctl_q.st;

endmodule

// File: rtl/cos_input_port.sv
module cos_input_port
    import cos_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int BW = BANK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NB*BW-1:0]     din,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    output logic                 irq_n
);

    localparam int TOTAL_W = NB * BW;

    logic [TOTAL_W-1:0] sync;
    logic [TOTAL_W-1:0] edge_vec;
    logic [NB-1:0]      bank_chg;
    logic [NB-1:0]      enable_q;
    logic [NB-1:0]      status_q;
    logic               pending;
    logic               rd_ack;
    logic               wr_mask;
    port_sel_t          sel;
    logic               unused_wdata_bits;

    assign rd_ack  = rd_en && (addr == OFS_CTRL);
    assign wr_mask = wr_en && (addr == OFS_CTRL);
    assign unused_wdata_bits = ^wdata[7:NB];

    cos_sync_stage #(.W(TOTAL_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .sync     (sync),
        .edge_vec (edge_vec)
    );

    cos_bank_reduce #(.NB(NB), .BW(BW)) u_reduce (
        .edge_vec (edge_vec),
        .bank_chg (bank_chg)
    );

    cos_status #(.NB(NB)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_chg (bank_chg),
        .wr_mask  (wr_mask),
        .mask_in  (wdata[NB-1:0]),
        .rd_ack   (rd_ack),
        .enable_q (enable_q),
        .status_q (status_q),
        .pending  (pending)
    );

    always_comb begin
        sel   = decode_port(addr);
        rdata = '0;
        if (addr == OFS_CTRL) begin
            rdata[NB-1:0]         = status_q;
            rdata[STAT_PEND_BIT]  = ~pending;
        end else if (sel.hit) begin
            rdata = sync[sel.bank*BW +: BW];
        end
    end

    assign irq_n = ~pending;

endmodule

// File: rtl/cos_input_port_chk.sv
module cos_input_port_chk #(
    parameter int NB = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    addr,
    input logic          rd_en,
    input logic          wr_en,
    input logic [7:0]    rdata,
    input logic          irq_n,
    input logic [NB-1:0] bank_chg,
    input logic [NB-1:0] enable_q,
    input logic [NB-1:0] status_q
);

    AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd3) |-> (rdata == 8'h00)); // R3

    AST_DISABLED_BANK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~enable_q) == '0)); // R5

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 3'd7) |=>
        ((status_q & $past(bank_chg & enable_q)) == $past(bank_chg & enable_q))); // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd7 && bank_chg == '0) |=> (status_q == '0) && irq_n); // R6

    AST_EDGE_SURVIVES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd7 && !wr_en && ((bank_chg & enable_q) != '0)) |=> !irq_n); // R7

    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en && bank_chg == '0) |=> $stable(status_q)); // R6

    AST_PEND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd7) |-> (rdata[7] == 1'b0) && (rdata[6] == irq_n)); // R9

endmodule

bind cos_input_port cos_input_port_chk #(.NB(NB)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .rdata    (rdata),
    .irq_n    (irq_n),
    .bank_chg (bank_chg),
    .enable_q (enable_q),
    .status_q (status_q)
);

// File: tb/cos_input_port_test.sv
`timescale 1ns/1ps
module cos_input_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] din = '0;
    logic [2:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cos_input_port uut (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .addr  (addr),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .wdata (wdata),
        .rdata (rdata),
        .irq_n (irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic read(input logic [2:0] a, output logic [7:0] v);
        addr  = a;
        rd_en = 1'b1;
        #1 v = rdata;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic write(input logic [2:0] a, input logic [7:0] v);
        addr  = a;
        wdata = v;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [2:0] ofs_of_bank(input int b);
        return (b < 3) ? 3'(b) : 3'(b + 1);
    endfunction

    function automatic logic [7:0] stat_exp(input logic [5:0] flags);
        return {1'b0, (flags == 6'd0), flags};
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [47:0] pat;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1: reset state
        peek(3'd7, v);
        check("R1 status after reset", v, 8'h40);
        check("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);

        // R2 / R3 / R5: data path under several patterns with all banks disabled
        for (int k = 0; k < 6; k++) begin
            for (int b = 0; b < 6; b++) begin
                pat[b*8 +: 8] = 8'((b * 37 + k * 53 + 1) & 255);
            end
            din = pat;
            wait_cyc(2);
            for (int b = 0; b < 6; b++) begin
                peek(ofs_of_bank(b), v);
                check("R2 input byte", v, pat[b*8 +: 8]);
            end
            peek(3'd3, v);
            check("R3 gap offset", v, 8'h00);
            wait_cyc(1);
            peek(3'd7, v);
            check("R5 disabled banks ignore edges", v, 8'h40);
            check("R5 irq_n stays high", {7'd0, irq_n}, 8'h01);
        end

        // R4 / R6 / R9: every input, rising then falling, all banks enabled
        din = '0;
        wait_cyc(4);
        write(3'd7, 8'h3F);
        for (int b = 0; b < 6; b++) begin
            for (int i = 0; i < 8; i++) begin
                for (int e = 0; e < 2; e++) begin
                    din[b*8 + i] = ~din[b*8 + i];
                    wait_cyc(3);
                    check("R9 irq_n low on edge", {7'd0, irq_n}, 8'h00);
                    read(3'd7, v);
                    check("R4 bank flag for edge", v, stat_exp(6'(1 << b)));
                    peek(3'd7, v);
                    check("R6 cleared after read", v, 8'h40);
                    check("R6 irq_n released", {7'd0, irq_n}, 8'h01);
                end
            end
        end

        // R5 / R8: sweep all mask values against a change on every bank
        for (int m = 0; m < 64; m++) begin
            write(3'd7, 8'(m));
            din = ~din;
            wait_cyc(3);
            peek(3'd7, v);
            check("R5 mask sweep status", v, stat_exp(6'(m)));
            check("R9 mask sweep irq_n", {7'd0, irq_n}, (m == 0) ? 8'h01 : 8'h00);
            read(3'd7, v);
        end

        // R8: disabling a bank drops its flag; writes elsewhere are ignored
        write(3'd7, 8'h3F);
        din[2*8] = ~din[2*8];
        din[4*8 + 3] = ~din[4*8 + 3];
        wait_cyc(3);
        write(3'd7, 8'h04);
        peek(3'd7, v);
        check("R8 disabled bank flag dropped", v, 8'h04);
        write(3'd0, 8'h00);
        write(3'd3, 8'h3F);
        peek(3'd7, v);
        check("R8 write to data offset ignored", v, 8'h04);
        din[2*8 + 1] = ~din[2*8 + 1];
        din[5*8] = ~din[5*8];
        wait_cyc(3);
        read(3'd7, v);
        check("R8 mask kept after other writes", v, 8'h04);
        write(3'd7, 8'h00);
        check("R9 irq_n after disable write", {7'd0, irq_n}, 8'h01);

        // R7: edge latching in the same cycle as the clearing read
        write(3'd7, 8'h3F);
        din[0] = ~din[0];
        wait_cyc(3);
        din[8] = ~din[8];
        wait_cyc(2);
        read(3'd7, v);
        check("R7 read before new edge", v, 8'h01);
        peek(3'd7, v);
        check("R7 new edge kept", v, 8'h02);
        read(3'd7, v);
        peek(3'd7, v);
        check("R7 cleared afterwards", v, 8'h40);

        // R9: writing zero releases a pending request
        din[40] = ~din[40];
        wait_cyc(3);
        check("R9 irq_n low before disable", {7'd0, irq_n}, 8'h00);
        write(3'd7, 8'h00);
        check("R9 irq_n high after zero write", {7'd0, irq_n}, 8'h01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule